// File: doc/BRIEF.md
# Protected Peripheral Clock Gating Controller

This block holds one 16-bit control word that decides which peripheral modules receive a clock enable. Software reaches the word through a small register bus with a select, a write strobe, an address and write data; reads are combinational and return the stored word. A write changes the word only while the protection-unlock input is high. A write attempted while locked leaves the word alone and raises a sticky violation flag.

Each stored bit passes through a fixed two-stage pipeline before it reaches the outputs. Each enabled peripheral then receives an enable of its own kind. The two controller-network peripherals get a pulse on every other system clock, from a free-running toggle flip-flop. The two serial-port peripherals follow an externally supplied one-cycle low-speed strobe. The remaining peripherals get a steady full-rate enable. The timebase-sync bit goes out as a plain level. Reserved positions cannot be written and always read as zero.

Top module: `pcg_top`

## Requirements
- R1: After reset the stored word is 0x0000, every bit of `clk_en` is 0, `tb_sync` is 0 and `prot_viol` is 0.
- R2: A write (`bus_sel`=1, `bus_wr`=1, `bus_addr`=0xC) sampled on a rising edge while `prot_unlock`=1 stores `bus_wdata` masked to the writable bits. A read of address 0xC returns the new stored word in the very next cycle, without waiting for the pipeline.
- R3: A write to address 0xC sampled while `prot_unlock`=0 leaves the stored word unchanged.
- R4: Bit positions 9, 7, 2, 1 and 0 are reserved. Data written there is discarded, they always read as 0, and their `clk_en` bits stay 0. Writable mask is 0xFD78.
- R5: If a write is sampled at rising edge N, the outputs show the old word up to edge N+1 and the new word from edge N+2 onward.
- R6: Bits 15 and 14 drive their `clk_en` bit high only on alternate cycles while the delayed bit is set. Over any two consecutive cycles such an output is high exactly once, and it is never high on two cycles in a row.
- R7: Bits 13 and 12 drive `clk_en` equal to `lowspd_stb` ANDed with the delayed bit, so they are 0 whenever the strobe is low.
- R8: Bits 11, 10, 8, 6, 5 and 4 drive `clk_en` as a steady level equal to the delayed bit.
- R9: Bit 3 is presented on `tb_sync` as a level equal to the delayed bit, and `clk_en[3]` is always 0.
- R10: A write to address 0xC attempted while `prot_unlock`=0 sets `prot_viol` from the next cycle. The flag stays set until reset.
- R11: Bus accesses to any other address neither change the stored word nor set `prot_viol`, and reads there return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | Write strobe, qualified by `bus_sel` |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, zero when not selected |
| prot_unlock | input | 1 | Write-protection unlock |
| lowspd_stb | input | 1 | One-cycle low-speed clock strobe |
| clk_en | output | DATA_W | Per-peripheral clock enables |
| tb_sync | output | 1 | Delayed timebase-sync level |
| prot_viol | output | 1 | Sticky locked-write violation flag |

## Verification
The bench builds the block with its defaults: a 16-bit word, a 4-bit address with the register at 0xC, a two-stage delay, writable mask 0xFD78, half-rate mask 0xC000 and low-speed mask 0x3000. These values cover every output class at once: alternating controller-network pulses, strobe-gated serial-port enables, steady full-rate enables, the sync level and reserved holes between them. Because the delay is only two stages, every write can be followed through both stages, so the bench checks the exact cycle at which each output changes.

// File: rtl/pcg_pkg.sv
package pcg_pkg;

  // Kind of enable each bit position produces
  typedef enum logic [2:0] {
    PCG_RT_OFF,
    PCG_RT_FULL,
    PCG_RT_HALF,
    PCG_RT_LOW,
    PCG_RT_LEVEL
  } pcg_rate_e;

  // Classify one bit position from the configuration masks
  function automatic pcg_rate_e pcg_rate_of(input int unsigned idx,
                                            input int unsigned wr_m,
                                            input int unsigned half_m,
                                            input int unsigned low_m,
                                            input int unsigned lvl_idx);
    if (wr_m[idx] == 1'b0) return PCG_RT_OFF;
    if (idx == lvl_idx)    return PCG_RT_LEVEL;
    if (half_m[idx])       return PCG_RT_HALF;
    if (low_m[idx])        return PCG_RT_LOW;
    return PCG_RT_FULL;
  endfunction

  // Enable value for one bit given its class and the shared timing sources
  function automatic logic pcg_gate(input pcg_rate_e rt,
                                    input logic      en_bit,
                                    input logic      half_ph,
                                    input logic      stb);
    logic g;
    case (rt)
      PCG_RT_FULL: g = 1'b1;
      PCG_RT_HALF: g = half_ph;
      PCG_RT_LOW:  g = stb;
      default:     g = 1'b0;
    endcase
    return en_bit & g;
  endfunction

endpackage

// File: rtl/pcg_ctrl_reg.sv
module pcg_ctrl_reg #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned REG_ADDR = 12,
  parameter int unsigned WR_MASK  = 32'h0000_FD78
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              prot_unlock,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] ctrl_q,
  output logic              wr_ok,
  output logic              wr_blocked,
  output logic              viol_q
);

  localparam logic [ADDR_W-1:0] HIT_ADDR = REG_ADDR[ADDR_W-1:0];
  localparam logic [DATA_W-1:0] WMASK    = WR_MASK[DATA_W-1:0];

  logic addr_hit;
  logic wr_try;

  assign addr_hit   = bus_sel && (bus_addr == HIT_ADDR);
  assign wr_try     = addr_hit && bus_wr;
  assign wr_ok      = wr_try && prot_unlock;
  assign wr_blocked = wr_try && !prot_unlock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_ok) begin
      ctrl_q <= bus_wdata & WMASK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol_q <= 1'b0;
    end else if (wr_blocked) begin
      viol_q <= 1'b1;
    end
  end

  assign bus_rdata = addr_hit ? ctrl_q : '0;

endmodule

// File: rtl/pcg_delay_line.sv
module pcg_delay_line #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    logic [W-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = d;
    end else begin : g_next
      assign stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_d;
    end
  end

  assign q = stage_q[DEPTH-1];

endmodule

// File: rtl/pcg_rate_gen.sv
module pcg_rate_gen
  import pcg_pkg::*;
#(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned WR_MASK   = 32'h0000_FD78,
  parameter int unsigned HALF_MASK = 32'h0000_C000,
  parameter int unsigned LOW_MASK  = 32'h0000_3000,
  parameter int unsigned SYNC_IDX  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] dly_q,
  input  logic              lowspd_stb,
  output logic [DATA_W-1:0] clk_en,
  output logic              tb_sync,
  output logic              half_ph
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) half_ph <= 1'b0;
    else        half_ph <= ~half_ph;
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    localparam pcg_rate_e RT = pcg_rate_of(i, WR_MASK, HALF_MASK, LOW_MASK, SYNC_IDX);
    assign clk_en[i] = pcg_gate(RT, dly_q[i], half_ph, lowspd_stb);
  end

  assign tb_sync = dly_q[SYNC_IDX];

endmodule

// File: rtl/pcg_top.sv
module pcg_top #(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned REG_ADDR  = 12,
  parameter int unsigned DELAY     = 2,
  parameter int unsigned WR_MASK   = 32'h0000_FD78,
  parameter int unsigned HALF_MASK = 32'h0000_C000,
  parameter int unsigned LOW_MASK  = 32'h0000_3000,
  parameter int unsigned SYNC_IDX  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              prot_unlock,
  input  logic              lowspd_stb,
  output logic [DATA_W-1:0] clk_en,
  output logic              tb_sync,
  output logic              prot_viol
);

  // Named internal events, visible to the bound checker
  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] dly_q;
  logic              wr_ok;
  logic              wr_blocked;
  logic              half_ph;

  pcg_ctrl_reg #(
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .REG_ADDR(REG_ADDR),
    .WR_MASK (WR_MASK)
  ) u_reg (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .prot_unlock(prot_unlock),
    .bus_rdata  (bus_rdata),
    .ctrl_q     (ctrl_q),
    .wr_ok      (wr_ok),
    .wr_blocked (wr_blocked),
    .viol_q     (prot_viol)
  );

  pcg_delay_line #(
    .W    (DATA_W),
    .DEPTH(DELAY)
  ) u_dly (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (ctrl_q),
    .q    (dly_q)
  );

  pcg_rate_gen #(
    .DATA_W   (DATA_W),
    .WR_MASK  (WR_MASK),
    .HALF_MASK(HALF_MASK),
    .LOW_MASK (LOW_MASK),
    .SYNC_IDX (SYNC_IDX)
  ) u_rate (
    .clk       (clk),
    .rst_n     (rst_n),
    .dly_q     (dly_q),
    .lowspd_stb(lowspd_stb),
    .clk_en    (clk_en),
    .tb_sync   (tb_sync),
    .half_ph   (half_ph)
  );

endmodule

// File: rtl/pcg_top_chk.sv
module pcg_top_chk #(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned REG_ADDR  = 12,
  parameter int unsigned DELAY     = 2,
  parameter int unsigned WR_MASK   = 32'h0000_FD78,
  parameter int unsigned HALF_MASK = 32'h0000_C000,
  parameter int unsigned LOW_MASK  = 32'h0000_3000,
  parameter int unsigned SYNC_IDX  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              prot_unlock,
  input logic              lowspd_stb,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [DATA_W-1:0] ctrl_q,
  input logic [DATA_W-1:0] dly_q,
  input logic [DATA_W-1:0] clk_en,
  input logic              prot_viol
);

  localparam logic [DATA_W-1:0] WM = WR_MASK[DATA_W-1:0];
  localparam logic [DATA_W-1:0] HM = HALF_MASK[DATA_W-1:0];
  localparam logic [DATA_W-1:0] LM = LOW_MASK[DATA_W-1:0];

  logic locked_try;
  assign locked_try = bus_sel && bus_wr && !prot_unlock &&
                      (bus_addr == REG_ADDR[ADDR_W-1:0]);

  // Independent model of the write-to-output pipeline
  logic [DATA_W-1:0] ref_q [DELAY];
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DELAY; k++) ref_q[k] <= '0;
    end else begin
      ref_q[0] <= ctrl_q;
      for (int k = 1; k < DELAY; k++) ref_q[k] <= ref_q[k-1];
    end
  end

  // R3
  locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked_try |=> $stable(ctrl_q));

  // R4
  rsvd_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & ~WM) == '0);

  // R5
  delay_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dly_q == ref_q[DELAY-1]);

  // R6
  half_alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((clk_en & HM) != '0) |=> ((clk_en & HM) == '0));

  // R7
  low_needs_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((clk_en & LM) != '0) |-> lowspd_stb);

  // R9
  sync_not_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en[SYNC_IDX] == 1'b0);

  // R10
  viol_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked_try |=> prot_viol);

  // R10
  viol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prot_viol |=> prot_viol);

endmodule

bind pcg_top pcg_top_chk #(
  .DATA_W   (DATA_W),
  .ADDR_W   (ADDR_W),
  .REG_ADDR (REG_ADDR),
  .DELAY    (DELAY),
  .WR_MASK  (WR_MASK),
  .HALF_MASK(HALF_MASK),
  .LOW_MASK (LOW_MASK),
  .SYNC_IDX (SYNC_IDX)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_sel    (bus_sel),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .prot_unlock(prot_unlock),
  .lowspd_stb (lowspd_stb),
  .bus_rdata  (bus_rdata),
  .ctrl_q     (ctrl_q),
  .dly_q      (dly_q),
  .clk_en     (clk_en),
  .prot_viol  (prot_viol)
);

// File: tb/pcg_top_tb_top.sv
module pcg_top_tb_top;

  localparam logic [15:0] FULLM = 16'h0D70;
  localparam logic [15:0] HALFM = 16'hC000;
  localparam logic [15:0] LOWM  = 16'h3000;
  localparam logic [3:0]  RA    = 4'hC;
  localparam logic [3:0]  OA    = 4'h3;

  // {unlock, write data, expected stored word afterwards}
  localparam logic [32:0] VEC [8] = '{
    {1'b1, 16'hFFFF, 16'hFD78},
    {1'b1, 16'h0000, 16'h0000},
    {1'b1, 16'h0287, 16'h0000},
    {1'b0, 16'hFFFF, 16'h0000},
    {1'b1, 16'hC000, 16'hC000},
    {1'b1, 16'h3008, 16'h3008},
    {1'b0, 16'h0000, 16'h3008},
    {1'b1, 16'h0D70, 16'h0D70}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        prot_unlock = 1'b0;
  logic        lowspd_stb = 1'b0;
  logic [15:0] clk_en;
  logic        tb_sync;
  logic        prot_viol;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pcg_top dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .prot_unlock(prot_unlock),
    .lowspd_stb (lowspd_stb),
    .clk_en     (clk_en),
    .tb_sync    (tb_sync),
    .prot_viol  (prot_viol)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [15:0] d, input logic unl);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; prot_unlock = unl;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; prot_unlock = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [15:0] v);
    bus_sel = 1'b1; bus_addr = a;
    #1 v = bus_rdata;
    bus_sel = 1'b0;
    #1;
  endtask

  // Checks all output classes for a settled word; consumes one clock
  task automatic check_outputs(input logic [15:0] w);
    logic [1:0] h0, h1;
    chk("R8", "full-rate enables", 32'(clk_en & FULLM), 32'(w & FULLM));
    chk("R9", "sync level", 32'(tb_sync), 32'(w[3]));
    chk("R9", "sync bit not gated", 32'(clk_en[3]), 32'h0);
    chk("R4", "reserved enables", 32'(clk_en & 16'h0287), 32'h0);
    chk("R7", "low enables with strobe low", 32'(clk_en & LOWM), 32'h0);
    lowspd_stb = 1'b1;
    #1 chk("R7", "low enables with strobe high", 32'(clk_en & LOWM), 32'(w & LOWM));
    lowspd_stb = 1'b0;
    #1 h0 = clk_en[15:14];
    @(negedge clk);
    h1 = clk_en[15:14];
    chk("R6", "half-rate high once in two cycles", 32'(h0 | h1), 32'(w[15:14]));
    chk("R6", "half-rate never two in a row", 32'(h0 & h1), 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] rv;
    logic [15:0] cur;
    logic        exp_viol;

    repeat (3) @(negedge clk);
    // R1: reset state
    bus_read(RA, rv);
    chk("R1", "reset word", 32'(rv), 32'h0);
    chk("R1", "reset enables", 32'(clk_en), 32'h0);
    chk("R1", "reset sync", 32'(tb_sync), 32'h0);
    chk("R1", "reset violation", 32'(prot_viol), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: other address, unlocked and locked
    bus_write(OA, 16'hFFFF, 1'b1);
    bus_write(OA, 16'hFFFF, 1'b0);
    repeat (2) @(negedge clk);
    bus_read(RA, rv);
    chk("R11", "word after foreign writes", 32'(rv), 32'h0);
    bus_read(OA, rv);
    chk("R11", "foreign read", 32'(rv), 32'h0);
    chk("R11", "no violation from foreign write", 32'(prot_viol), 32'h0);
    chk("R11", "enables untouched", 32'(clk_en), 32'h0);

    cur = 16'h0000;
    exp_viol = 1'b0;
    foreach (VEC[i]) begin
      logic [15:0] prev;
      prev = cur;
      cur = VEC[i][15:0];
      exp_viol = exp_viol | ~VEC[i][32];
      bus_write(RA, VEC[i][31:16], VEC[i][32]);
      // one edge after the write edge
      bus_read(RA, rv);
      chk(VEC[i][32] ? "R2" : "R3", "readback", 32'(rv), 32'(cur));
      chk("R4", "reserved readback", 32'(rv & 16'h0287), 32'h0);
      chk("R10", "violation flag", 32'(prot_viol), 32'(exp_viol));
      chk("R5", "old word after write edge", 32'(clk_en & FULLM), 32'(prev & FULLM));
      @(negedge clk);
      chk("R5", "old word one edge later", 32'(clk_en & FULLM), 32'(prev & FULLM));
      chk("R5", "old sync one edge later", 32'(tb_sync), 32'(prev[3]));
      @(negedge clk);
      chk("R5", "new word two edges later", 32'(clk_en & FULLM), 32'(cur & FULLM));
      check_outputs(cur);
    end

    // R10: flag survives further unlocked writes
    bus_write(RA, 16'h0010, 1'b1);
    repeat (3) @(negedge clk);
    chk("R10", "sticky after unlocked write", 32'(prot_viol), 32'h1);

    // R1: reset mid-run clears everything
    rst_n = 1'b0;
    #1;
    bus_read(RA, rv);
    chk("R1", "word after reset", 32'(rv), 32'h0);
    chk("R1", "enables after reset", 32'(clk_en), 32'h0);
    chk("R1", "violation after reset", 32'(prot_viol), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule